// File: doc/BRIEF.md
# Multi-Block Erase Window Collector

This block sits behind the write-cycle decoder of a NOR flash command interface. It tracks the six-write block-erase command (two unlock writes, an erase setup, two more unlock writes and a block-erase code at the address of the target block). It then keeps an acceptance window open, during which further block-erase writes each add one more block to a selected-block bitmap. Each accepted write restarts the window. When the window runs out with no new command, the block raises a one-cycle erase-start pulse and holds the bitmap steady for the erase engine until that engine reports completion.

The window length is counted in ticks of an external timebase, so the same logic serves a 50 µs window on silicon and a few ticks in simulation. A write inside the window that is neither a block-erase nor an erase-suspend code cancels the whole operation: the bitmap clears and the block pulses an abort-to-read output. The erase-suspend code only raises a suspend-request pulse, both in the window and during the erase.

Top module: `mbe_collector`

## Requirements
- R1: After reset the block bitmap is all zero and busy, erase_start, abort_rd and suspend_req are low.
- R2: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@block address, in that order, select that block and raise busy without pulsing erase_start. Unlock addresses compare the low 11 address bits. Commands compare the low 8 data bits.
- R3: Bits 19..12 of the address pick the block. When bits 19..15 are all zero, bits 14..12 give the bitmap index 0..7. Otherwise the index is 7 plus the value of bits 19..15, giving 8..38.
- R4: Inside the window, a write of 30h at any address adds that address's block to the bitmap. Earlier selections stay set, and the window restarts.
- R5: The window counts timebase ticks only while the write strobe is high, restarting at every strobe falling edge. The tick that makes WIN_TICKS counted ticks produces a single one-cycle erase_start, and busy stays high.
- R6: Inside the window, any write whose data is not 30h or the suspend code pulses abort_rd, clears the bitmap, drops busy, and no erase_start follows.
- R7: A write of the suspend code (B0h) inside the window or during the erase pulses suspend_req. It leaves the bitmap and busy unchanged and does not abort.
- R8: During the erase every write other than the suspend code is ignored: the bitmap does not change and no abort or erase_start pulse occurs.
- R9: erase_done during the erase clears the bitmap, drops busy, and a new six-write sequence is then accepted.
- R10: A write that breaks the unlock/setup order (wrong data or wrong unlock address) returns to idle without selecting a block or raising busy.
- R11: The address is captured on the falling edge of the write strobe and the data on its rising edge. An address change while the strobe is low does not alter the selected block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Write strobe, active low, synchronous to clk |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| tick | input | 1 | One-cycle timebase tick |
| erase_done | input | 1 | Erase engine finished |
| blk_sel | output | NBLK | Selected-block bitmap |
| erase_start | output | 1 | One-cycle pulse when the window expires |
| busy | output | 1 | Window open or erase running |
| abort_rd | output | 1 | One-cycle pulse on cancellation, back to read |
| suspend_req | output | 1 | One-cycle pulse on a suspend-code write |

## Verification
The assertions assume that wr_n is already synchronous to clk and that each strobe low phase lasts at least one clock. They also assume that erase_done is only raised by an engine that was started, and that WIN_TICKS is at least 2, so that a window cannot expire in the cycle a command lands. The bench drives every strobe edge and tick on the falling clock edge, keeps strobes low for two cycles, and separates ticks from writes. It issues erase_done only after it has seen erase_start. Ticks are given while the strobe is low in only one scenario, and that scenario exists to show they are not counted.

// File: rtl/mbe_pkg.sv
package mbe_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_UNL1,
      S_UNL2,
      S_SETUP,
      S_UNL3,
      S_UNL4,
      S_WIN,
      S_ERASE
   } seq_t;

   localparam logic [7:0] CODE_UNL_A = 8'hAA;
   localparam logic [7:0] CODE_UNL_B = 8'h55;
   localparam logic [7:0] CODE_SETUP = 8'h80;
endpackage

// File: rtl/mbe_strobe.sv
module mbe_strobe #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              fall_p,
   output logic              cmd_p,
   output logic              strobe_hi,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data
);
   logic wr_q;
   logic fall_now, rise_now;

   assign fall_now  = wr_q & ~wr_n;
   assign rise_now  = ~wr_q & wr_n;
   assign strobe_hi = wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q     <= 1'b1;
         fall_p   <= 1'b0;
         cmd_p    <= 1'b0;
         cmd_addr <= '0;
         cmd_data <= '0;
      end else begin
         wr_q   <= wr_n;
         fall_p <= fall_now;
         cmd_p  <= rise_now;
         if (fall_now) cmd_addr <= wr_addr;
         if (rise_now) cmd_data <= wr_data;
      end
   end
endmodule

// File: rtl/mbe_blkmap.sv
module mbe_blkmap #(
   parameter int ADDR_W     = 20,
   parameter int BLK_LSB    = 12,
   parameter int SMALL_BITS = 3,
   parameter int LARGE_BITS = 5,
   parameter int NBLK       = 39
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NBLK-1:0]   onehot
);
   localparam int SMALL_N   = 1 << SMALL_BITS;
   localparam int LARGE_LSB = BLK_LSB + SMALL_BITS;
   localparam int IDX_W     = $clog2(NBLK);

   logic [SMALL_BITS-1:0] small_f;
   logic [LARGE_BITS-1:0] large_f;
   logic [IDX_W-1:0]      idx;

   assign small_f = addr[BLK_LSB +: SMALL_BITS];
   assign large_f = addr[LARGE_LSB +: LARGE_BITS];

   always_comb begin
      if (large_f == '0) idx = IDX_W'(small_f);
      else               idx = IDX_W'(large_f) + IDX_W'(SMALL_N - 1);
   end

   for (genvar b = 0; b < NBLK; b++) begin : g_bit
      assign onehot[b] = (idx == IDX_W'(b));
   end
endmodule

// File: rtl/mbe_wintimer.sv
module mbe_wintimer #(
   parameter int WIN_TICKS = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic count_en,
   input  logic tick,
   output logic expire
);
   localparam int CNT_W = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_TICKS - 1);

   logic [CNT_W-1:0] cnt;
   logic             step;

   assign step   = run && !restart && tick && count_en;
   assign expire = step && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (restart || !run) cnt <= '0;
      else if (step)           cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/mbe_collector.sv
module mbe_collector #(
   parameter int          ADDR_W     = 20,
   parameter int          DATA_W     = 8,
   parameter int          BLK_LSB    = 12,
   parameter int          SMALL_BITS = 3,
   parameter int          LARGE_BITS = 5,
   parameter int          UNL_W      = 11,
   parameter logic [10:0] UNL_ADDR_A = 11'h555,
   parameter logic [10:0] UNL_ADDR_B = 11'h2AA,
   parameter logic [7:0]  CODE_BLK   = 8'h30,
   parameter logic [7:0]  CODE_SUSP  = 8'hB0,
   parameter int          WIN_TICKS  = 50,
   localparam int         NBLK       = (1 << SMALL_BITS) + (1 << LARGE_BITS) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick,
   input  logic              erase_done,
   output logic [NBLK-1:0]   blk_sel,
   output logic              erase_start,
   output logic              busy,
   output logic              abort_rd,
   output logic              suspend_req
);
   import mbe_pkg::*;

   if (DATA_W < 8) begin : g_bad_data
      $error("mbe_collector: DATA_W must be at least 8");
   end
   if (WIN_TICKS < 2) begin : g_bad_win
      $error("mbe_collector: WIN_TICKS must be at least 2");
   end
   if (ADDR_W != BLK_LSB + SMALL_BITS + LARGE_BITS) begin : g_bad_addr
      $error("mbe_collector: block field must end at the top address bit");
   end
   if (UNL_W > 11 || UNL_W > ADDR_W) begin : g_bad_unl
      $error("mbe_collector: UNL_W out of range");
   end

   logic              fall_p, cmd_p, strobe_hi;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_data;
   logic [NBLK-1:0]   blk_hit;
   logic              expire;
   logic              erasing;
   logic [7:0]        code;
   seq_t              st;

   mbe_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
      .fall_p(fall_p), .cmd_p(cmd_p), .strobe_hi(strobe_hi),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data)
   );

   mbe_blkmap #(
      .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .SMALL_BITS(SMALL_BITS),
      .LARGE_BITS(LARGE_BITS), .NBLK(NBLK)
   ) u_map (
      .addr(cmd_addr), .onehot(blk_hit)
   );

   mbe_wintimer #(.WIN_TICKS(WIN_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st == S_WIN), .restart(fall_p),
      .count_en(strobe_hi), .tick(tick), .expire(expire)
   );

   assign code    = cmd_data[7:0];
   assign erasing = (st == S_ERASE);
   assign busy    = (st == S_WIN) || erasing;

   function automatic logic at_unl(input logic [ADDR_W-1:0] a, input logic [10:0] ref_a);
      return a[UNL_W-1:0] == ref_a[UNL_W-1:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         blk_sel     <= '0;
         erase_start <= 1'b0;
         abort_rd    <= 1'b0;
         suspend_req <= 1'b0;
      end else begin
         erase_start <= 1'b0;
         abort_rd    <= 1'b0;
         suspend_req <= 1'b0;
         case (st)
            S_IDLE:
               if (cmd_p && at_unl(cmd_addr, UNL_ADDR_A) && code == CODE_UNL_A) st <= S_UNL1;
            S_UNL1:
               if (cmd_p) st <= (at_unl(cmd_addr, UNL_ADDR_B) && code == CODE_UNL_B) ? S_UNL2 : S_IDLE;
            S_UNL2:
               if (cmd_p) st <= (at_unl(cmd_addr, UNL_ADDR_A) && code == CODE_SETUP) ? S_SETUP : S_IDLE;
            S_SETUP:
               if (cmd_p) st <= (at_unl(cmd_addr, UNL_ADDR_A) && code == CODE_UNL_A) ? S_UNL3 : S_IDLE;
            S_UNL3:
               if (cmd_p) st <= (at_unl(cmd_addr, UNL_ADDR_B) && code == CODE_UNL_B) ? S_UNL4 : S_IDLE;
            S_UNL4:
               if (cmd_p) begin
                  if (code == CODE_BLK) begin
                     blk_sel <= blk_hit;
                     st      <= S_WIN;
                  end else begin
                     st <= S_IDLE;
                  end
               end
            S_WIN:
               if (cmd_p) begin
                  if (code == CODE_BLK) begin
                     blk_sel <= blk_sel | blk_hit;
                  end else if (code == CODE_SUSP) begin
                     suspend_req <= 1'b1;
                  end else begin
                     abort_rd <= 1'b1;
                     blk_sel  <= '0;
                     st       <= S_IDLE;
                  end
               end else if (expire) begin
                  erase_start <= 1'b1;
                  st          <= S_ERASE;
               end
            S_ERASE: begin
               if (cmd_p && code == CODE_SUSP) suspend_req <= 1'b1;
               if (erase_done) begin
                  blk_sel <= '0;
                  st      <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mbe_collector_chk.sv
module mbe_collector_chk #(
   parameter int NBLK = 39
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            erasing,
   input logic [NBLK-1:0] blk_sel,
   input logic            erase_start,
   input logic            abort_rd,
   input logic            erase_done
);
   assert_start_has_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> (blk_sel != '0));

   assert_start_enters_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> erasing);

   assert_abort_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_rd |-> (blk_sel == '0 && !busy));

   assert_abort_start_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erase_start, abort_rd}));

   assert_map_frozen_in_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (erasing && $past(erasing)) |-> $stable(blk_sel));

   assert_done_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (erasing && erase_done) |=> (!busy && blk_sel == '0));
endmodule

bind mbe_collector mbe_collector_chk #(.NBLK(NBLK)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .erasing(erasing), .blk_sel(blk_sel),
   .erase_start(erase_start), .abort_rd(abort_rd), .erase_done(erase_done)
);

// File: tb/tb_mbe_collector.sv
`timescale 1ns/1ps
module tb_mbe_collector;
   localparam int NB  = 39;
   localparam int WIN = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_n = 1'b1;
   logic [19:0]   wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          tick = 1'b0;
   logic          erase_done = 1'b0;
   logic [NB-1:0] blk_sel;
   logic          erase_start, busy, abort_rd, suspend_req;

   int n_chk = 0, n_fail = 0;
   int n_start = 0, n_abort = 0, n_susp = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   mbe_collector #(.WIN_TICKS(WIN)) dut (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
      .tick(tick), .erase_done(erase_done), .blk_sel(blk_sel),
      .erase_start(erase_start), .busy(busy), .abort_rd(abort_rd), .suspend_req(suspend_req)
   );

   always @(negedge clk) begin
      if (erase_start) n_start++;
      if (abort_rd)    n_abort++;
      if (suspend_req) n_susp++;
   end

   function automatic logic [NB-1:0] exp_map(input logic [19:0] a);
      int hi = int'(a[19:15]);
      int lo = int'(a[14:12]);
      int i  = (hi == 0) ? lo : 7 + hi;
      return NB'(1) << i;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [19:0] a, input logic [7:0] d);
      @(negedge clk); wr_addr = a; wr_data = d; wr_n = 1'b0;
      repeat (2) @(negedge clk);
      wr_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic seq(input logic [19:0] blk);
      wr(20'h555, 8'hAA); wr(20'h2AA, 8'h55); wr(20'h555, 8'h80);
      wr(20'h555, 8'hAA); wr(20'h2AA, 8'h55); wr(blk, 8'h30);
   endtask

   task automatic finish_erase();
      @(negedge clk); erase_done = 1'b1;
      @(negedge clk); erase_done = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 map", 64'(blk_sel), 64'h0);
      check("R1 busy", 64'(busy), 64'h0);
      check("R1 pulses", 64'(n_start + n_abort + n_susp), 64'h0);
   endtask

   task automatic t_basic();
      int s0 = n_start;
      seq(20'h00000);
      check("R2 map", 64'(blk_sel), 64'(exp_map(20'h00000)));
      check("R2 busy", 64'(busy), 64'h1);
      check("R2 no start", 64'(n_start), 64'(s0));
      ticks(WIN);
      check("R5 one start", 64'(n_start), 64'(s0 + 1));
      check("R5 busy in erase", 64'(busy), 64'h1);
      finish_erase();
      check("R9 map clear", 64'(blk_sel), 64'h0);
      check("R9 busy low", 64'(busy), 64'h0);
   endtask

   task automatic t_multi();
      int s0 = n_start, a0 = n_abort, p0 = n_susp;
      logic [NB-1:0] m;
      seq(20'h07000);
      m = exp_map(20'h07000);
      check("R3 small top", 64'(blk_sel), 64'(m));
      ticks(WIN - 1);
      wr(20'h08000, 8'h30); m |= exp_map(20'h08000);
      check("R4 add large first", 64'(blk_sel), 64'(m));
      ticks(WIN - 1);
      wr(20'hF8000, 8'h30); m |= exp_map(20'hF8000);
      ticks(WIN - 1);
      wr(20'h12345, 8'h30); m |= exp_map(20'h12345);
      check("R3 R4 map", 64'(blk_sel), 64'(m));
      ticks(WIN - 1);
      check("R4 window restarted", 64'(n_start), 64'(s0));
      ticks(1);
      check("R5 start after last", 64'(n_start), 64'(s0 + 1));
      wr(20'h20000, 8'h30);
      wr(20'h00555, 8'hF0);
      check("R8 map unchanged", 64'(blk_sel), 64'(m));
      check("R8 no abort", 64'(n_abort), 64'(a0));
      wr(20'h00000, 8'hB0);
      check("R7 suspend in erase", 64'(n_susp), 64'(p0 + 1));
      check("R8 busy held", 64'(busy), 64'h1);
      finish_erase();
      check("R9 cleared", 64'(blk_sel), 64'h0);
   endtask

   task automatic t_abort();
      int s0 = n_start, a0 = n_abort;
      seq(20'h01000);
      wr(20'h00555, 8'hF0);
      check("R6 abort pulse", 64'(n_abort), 64'(a0 + 1));
      check("R6 map clear", 64'(blk_sel), 64'h0);
      check("R6 busy low", 64'(busy), 64'h0);
      ticks(WIN + 1);
      check("R6 no start", 64'(n_start), 64'(s0));
   endtask

   task automatic t_susp_win();
      int s0 = n_start, a0 = n_abort, p0 = n_susp;
      seq(20'h40000);
      wr(20'h00000, 8'hB0);
      check("R7 suspend pulse", 64'(n_susp), 64'(p0 + 1));
      check("R7 no abort", 64'(n_abort), 64'(a0));
      check("R7 map kept", 64'(blk_sel), 64'(exp_map(20'h40000)));
      ticks(WIN);
      check("R7 window still runs", 64'(n_start), 64'(s0 + 1));
      finish_erase();
      check("R9 reusable", 64'(busy), 64'h0);
   endtask

   task automatic t_badseq();
      wr(20'h555, 8'hAA); wr(20'h2AA, 8'h55); wr(20'h555, 8'h80);
      wr(20'h555, 8'hAA); wr(20'h2AA, 8'h12); wr(20'h00000, 8'h30);
      check("R10 wrong data busy", 64'(busy), 64'h0);
      wr(20'h123, 8'hAA); wr(20'h2AA, 8'h55); wr(20'h555, 8'h80);
      wr(20'h555, 8'hAA); wr(20'h2AA, 8'h55); wr(20'h00000, 8'h30);
      check("R10 wrong addr busy", 64'(busy), 64'h0);
      check("R10 map", 64'(blk_sel), 64'h0);
   endtask

   task automatic t_latch();
      wr(20'h555, 8'hAA); wr(20'h2AA, 8'h55); wr(20'h555, 8'h80);
      wr(20'h555, 8'hAA); wr(20'h2AA, 8'h55);
      @(negedge clk); wr_addr = 20'h03000; wr_data = 8'h00; wr_n = 1'b0;
      @(negedge clk); wr_addr = 20'h90000; wr_data = 8'h30;
      @(negedge clk); wr_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 fall address", 64'(blk_sel), 64'(exp_map(20'h03000)));
      check("R11 rise data", 64'(busy), 64'h1);
   endtask

   task automatic t_stall();
      int s0 = n_start;
      @(negedge clk); wr_addr = 20'h0; wr_data = 8'hB0; wr_n = 1'b0;
      for (int i = 0; i < WIN + 2; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
      @(negedge clk); wr_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R5 no count while low", 64'(n_start), 64'(s0));
      ticks(WIN - 1);
      check("R5 restart at fall", 64'(n_start), 64'(s0));
      ticks(1);
      check("R5 expiry", 64'(n_start), 64'(s0 + 1));
      finish_erase();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_multi();
      t_abort();
      t_susp_win();
      t_badseq();
      t_latch();
      t_stall();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #500000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule